// File: doc/BRIEF.md
# Strided, Triangular and Indirect Stream Address Generator

This block turns a loop access pattern into a series of address groups. Each group holds one address for each of VL vector lanes and a mask that marks which lanes are live. Software writes a descriptor while the block is idle, then pulses start. From then on the consumer only takes groups from a ready/valid output. It does no index arithmetic of its own and stops when it sees the end-of-stream flag.

There are three shapes. The rectangular shape walks rows with an outer stride and elements with an inner stride. The triangular shape gives row i exactly i+1 elements. The indirect shape builds each address from an index value taken from a companion ready/valid index input. A group never crosses a row boundary. When a row's element count is not a multiple of VL, the unused lanes of its last group are masked off, so every row is padded to whole vectors. Element order is always linear: rows in ascending order, and within a row the columns in ascending order, with lane 0 holding the lowest column.

Top module: `stream_addr_gen`

## Requirements
- R1: After reset, out_valid, idx_ready and out_eos are all low.
- R2: In rectangular mode (mode code 0), live lane l of the group that starts at column c of row r has address base + ((r*ostride + (c+l)*istride) << esize). esize is a log2 code: 0, 1, 2, 3 select 1, 2, 4, 8 bytes. All arithmetic is modulo 2^AW.
- R3: Each row is split into groups that start at columns 0, VL, 2*VL and so on. Mask bit l is set exactly when c+l is below the row length. The address output of a lane whose mask bit is clear is zero.
- R4: In triangular mode (mode code 1), row r has r+1 elements and the inner length field is ignored. Addresses follow the R2 formula.
- R5: In indirect mode (mode code 2), every row has the inner length number of elements. Index values are taken in row-major element order, and live lane l has address base + (index << esize). out_valid rises only once all live lanes of the group have their indices. idx_ready is high only in indirect mode, and only while the current group still lacks indices.
- R6: out_eor is high on the last group of every row. out_eos is high together with out_eor on the final group of the stream, and on no other group.
- R7: While out_valid is high and out_ready is low, out_valid stays high and the address, mask and flag outputs keep their values.
- R8: While a stream is running, start pulses and descriptor writes are ignored.
- R9: If the outer length is zero, or the inner length is zero in a non-triangular mode, start produces no group. out_eos is high for exactly one cycle, in the cycle after start is sampled, with out_valid low.
- R10: In the cycle after the final group is accepted, out_valid is low and a new start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe, honoured only when idle |
| cfg_mode | input | 2 | Shape: 0 rectangular, 1 triangular, 2 indirect |
| cfg_esize | input | 2 | log2 of element size in bytes |
| cfg_base | input | AW | Base byte address |
| cfg_istride | input | AW | Inner stride in elements |
| cfg_ostride | input | AW | Outer stride in elements |
| cfg_ilen | input | LW | Elements per row (non-triangular modes) |
| cfg_olen | input | LW | Number of rows |
| start | input | 1 | Launches the stream held in the descriptor |
| out_valid | output | 1 | Address group is valid |
| out_ready | input | 1 | Consumer accepts the group |
| out_addr | output | VL*AW | Lane addresses, lane l at bits l*AW upward |
| out_mask | output | VL | Live-lane mask |
| out_eor | output | 1 | Last group of a row |
| out_eos | output | 1 | End of stream |
| idx_valid | input | 1 | Index value offered |
| idx_ready | output | 1 | Index value accepted |
| idx_data | input | AW | Index value in elements |

## Verification
A wrong row or column counter shows up at once: the next accepted group carries a misplaced address, a mask with the wrong width, or a misplaced row-end flag. A triangular row-length error appears in the second row at the latest. In indirect mode, a slot counter that drifts either releases a group early, which is seen in the same cycle as valid rising before its indices have arrived, or sends an index to the wrong lane, which is seen in that group's addresses. A stale state at the end of a stream appears one cycle after the final handshake, as a valid that does not drop or an extra end pulse.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic [1:0] {
        MODE_RECT = 2'd0,
        MODE_TRI  = 2'd1,
        MODE_IND  = 2'd2,
        MODE_RSVD = 2'd3
    } sag_mode_e;
endpackage

// File: rtl/sag_walker.sv
module sag_walker
    import sag_pkg::*;
#(
    parameter int VL = 4,
    parameter int LW = 8,
    parameter int CW = $clog2(VL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  sag_mode_e     mode,
    input  logic [LW-1:0] ilen,
    input  logic [LW-1:0] olen,
    input  logic          adv,
    output logic          busy,
    output logic [LW-1:0] row,
    output logic [LW:0]   col,
    output logic [CW-1:0] lanes,
    output logic          last_grp,
    output logic          last_row,
    output logic          empty_pulse
);
    localparam int RW = LW + 1;

    typedef struct packed {
        logic          busy;
        logic          empty;
        logic [LW-1:0] row;
        logic [RW-1:0] col;
    } walk_t;

    walk_t w_d, w_q;
    logic [RW-1:0] rowlen, remain;

    always_comb begin
        rowlen   = (mode == MODE_TRI) ? ({1'b0, w_q.row} + RW'(1)) : {1'b0, ilen};
        remain   = rowlen - w_q.col;
        last_grp = remain <= RW'(VL);
        lanes    = last_grp ? CW'(remain) : CW'(VL);
        last_row = w_q.row == (olen - LW'(1));

        w_d       = w_q;
        w_d.empty = 1'b0;
        if (!w_q.busy) begin
            if (start) begin
                if (olen == '0 || (mode != MODE_TRI && ilen == '0)) begin
                    w_d.empty = 1'b1;
                end else begin
                    w_d.busy = 1'b1;
                    w_d.row  = '0;
                    w_d.col  = '0;
                end
            end
        end else if (adv) begin
            if (last_grp) begin
                w_d.col = '0;
                if (last_row) w_d.busy = 1'b0;
                else          w_d.row  = w_q.row + LW'(1);
            end else begin
                w_d.col = w_q.col + RW'(VL);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign busy        = w_q.busy;
    assign row         = w_q.row;
    assign col         = w_q.col;
    assign empty_pulse = w_q.empty;

    // R9
    empty_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.empty |=> !w_q.empty);

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.busy && !adv |=> w_q.busy);
endmodule

// File: rtl/sag_idx_collect.sv
module sag_idx_collect #(
    parameter int VL = 4,
    parameter int AW = 32,
    parameter int CW = $clog2(VL + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic [CW-1:0]         lanes,
    input  logic                  idx_valid,
    input  logic [AW-1:0]         idx_data,
    input  logic                  grp_fire,
    output logic                  idx_ready,
    output logic                  full,
    output logic [VL-1:0][AW-1:0] slots
);
    typedef struct packed {
        logic [CW-1:0]         cnt;
        logic [VL-1:0][AW-1:0] slot;
    } col_t;

    col_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        idx_ready = enable && (c_q.cnt < lanes);
        full      = enable && (c_q.cnt == lanes);
        if (idx_ready && idx_valid) begin
            for (int l = 0; l < VL; l++) begin
                if (CW'(l) == c_q.cnt) c_d.slot[l] = idx_data;
            end
            c_d.cnt = c_q.cnt + CW'(1);
        end
        if (grp_fire || !enable) c_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign slots = c_q.slot;

    // R5
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> c_q.cnt <= lanes);
endmodule

// File: rtl/sag_lane_gen.sv
module sag_lane_gen
    import sag_pkg::*;
#(
    parameter int VL = 4,
    parameter int AW = 32,
    parameter int LW = 8,
    parameter int CW = $clog2(VL + 1)
) (
    input  sag_mode_e             mode,
    input  logic [AW-1:0]         base,
    input  logic [1:0]            esize,
    input  logic [AW-1:0]         istride,
    input  logic [AW-1:0]         ostride,
    input  logic [LW-1:0]         row,
    input  logic [LW:0]           col,
    input  logic [CW-1:0]         lanes,
    input  logic [VL-1:0][AW-1:0] slots,
    output logic [VL*AW-1:0]      addr,
    output logic [VL-1:0]         mask
);
    logic [AW-1:0] row_off;
    assign row_off = AW'(row) * ostride;

    for (genvar l = 0; l < VL; l++) begin : g_lane
        logic          on;
        logic [AW-1:0] off;
        always_comb begin
            on = CW'(l) < lanes;
            if (mode == MODE_IND) off = slots[l];
            else                  off = row_off + (AW'(col) + AW'(l)) * istride;
        end
        assign mask[l]          = on;
        assign addr[l*AW +: AW] = on ? (base + (off << esize)) : '0;
    end
endmodule

// File: rtl/stream_addr_gen.sv
module stream_addr_gen
    import sag_pkg::*;
#(
    parameter int VL = 4,
    parameter int AW = 32,
    parameter int LW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_esize,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_istride,
    input  logic [AW-1:0]    cfg_ostride,
    input  logic [LW-1:0]    cfg_ilen,
    input  logic [LW-1:0]    cfg_olen,
    input  logic             start,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VL*AW-1:0] out_addr,
    output logic [VL-1:0]    out_mask,
    output logic             out_eor,
    output logic             out_eos,
    input  logic             idx_valid,
    output logic             idx_ready,
    input  logic [AW-1:0]    idx_data
);
    localparam int CW = $clog2(VL + 1);

    typedef struct packed {
        sag_mode_e     mode;
        logic [1:0]    esize;
        logic [AW-1:0] base;
        logic [AW-1:0] istride;
        logic [AW-1:0] ostride;
        logic [LW-1:0] ilen;
        logic [LW-1:0] olen;
    } desc_t;

    desc_t d_d, d_q;

    logic                  busy, last_grp, last_row, empty_pulse, full, fire, ind;
    logic [LW-1:0]         row;
    logic [LW:0]           col;
    logic [CW-1:0]         lanes;
    logic [VL-1:0][AW-1:0] slots;

    always_comb begin
        d_d = d_q;
        if (cfg_we && !busy) begin
            d_d.mode    = sag_mode_e'(cfg_mode);
            d_d.esize   = cfg_esize;
            d_d.base    = cfg_base;
            d_d.istride = cfg_istride;
            d_d.ostride = cfg_ostride;
            d_d.ilen    = cfg_ilen;
            d_d.olen    = cfg_olen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign ind       = busy && (d_q.mode == MODE_IND);
    assign out_valid = busy && (!ind || full);
    assign fire      = out_valid && out_ready;
    assign out_eor   = out_valid && last_grp;
    assign out_eos   = (out_valid && last_grp && last_row) || empty_pulse;

    sag_walker #(.VL(VL), .LW(LW), .CW(CW)) walk_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(d_q.mode),
        .ilen(d_q.ilen), .olen(d_q.olen), .adv(fire), .busy(busy),
        .row(row), .col(col), .lanes(lanes), .last_grp(last_grp),
        .last_row(last_row), .empty_pulse(empty_pulse)
    );

    sag_idx_collect #(.VL(VL), .AW(AW), .CW(CW)) coll_i (
        .clk(clk), .rst_n(rst_n), .enable(ind), .lanes(lanes),
        .idx_valid(idx_valid), .idx_data(idx_data), .grp_fire(fire),
        .idx_ready(idx_ready), .full(full), .slots(slots)
    );

    sag_lane_gen #(.VL(VL), .AW(AW), .LW(LW), .CW(CW)) lane_i (
        .mode(d_q.mode), .base(d_q.base), .esize(d_q.esize),
        .istride(d_q.istride), .ostride(d_q.ostride), .row(row), .col(col),
        .lanes(lanes), .slots(slots), .addr(out_addr), .mask(out_mask)
    );

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) &&
        $stable(out_mask) && $stable(out_eor) && $stable(out_eos));

    // R6
    eos_with_eor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eos |-> out_eor);

    // R5
    idx_out_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(idx_ready && out_valid));

    // R3
    mask_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask[0] && ((out_mask & (out_mask + 1'b1)) == '0));

    // R10
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eos |=> !out_valid);
endmodule

// File: tb/stream_addr_gen_tb_top.sv
module stream_addr_gen_tb_top;
    localparam int VL = 4;
    localparam int AW = 32;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_mode = '0, cfg_esize = '0;
    logic [AW-1:0] cfg_base = '0, cfg_istride = '0, cfg_ostride = '0;
    logic [LW-1:0] cfg_ilen = '0, cfg_olen = '0;
    logic start = 1'b0;
    logic out_valid, out_eor, out_eos, idx_ready;
    logic out_ready = 1'b0;
    logic [VL*AW-1:0] out_addr;
    logic [VL-1:0] out_mask;
    logic idx_valid = 1'b0;
    logic [AW-1:0] idx_data = '0;

    int checks = 0;
    int fails = 0;

    int t_mode, t_esz, t_il, t_ol;
    logic [AW-1:0] t_base, t_is, t_os;

    always #5 clk = ~clk;

    stream_addr_gen #(.VL(VL), .AW(AW), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_esize(cfg_esize), .cfg_base(cfg_base), .cfg_istride(cfg_istride),
        .cfg_ostride(cfg_ostride), .cfg_ilen(cfg_ilen), .cfg_olen(cfg_olen),
        .start(start), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_mask(out_mask), .out_eor(out_eor),
        .out_eos(out_eos), .idx_valid(idx_valid), .idx_ready(idx_ready),
        .idx_data(idx_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [VL*AW+7:0] act, input logic [VL*AW+7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] idx_of(int p);
        return AW'((p * 37 + 11) & 'hFFF);
    endfunction

    function automatic int row_len(int r);
        return (t_mode == 1) ? r + 1 : t_il;
    endfunction

    function automatic logic [AW-1:0] lane_addr(int r, int c);
        logic [AW-1:0] off;
        if (t_mode == 2) off = idx_of(r * t_il + c);
        else off = AW'(r) * t_os + AW'(c) * t_is;
        return t_base + (off << t_esz);
    endfunction

    task automatic load_desc(input int m, input int e, input logic [AW-1:0] b,
                             input logic [AW-1:0] is, input logic [AW-1:0] os,
                             input int il, input int ol);
        t_mode = m; t_esz = e; t_base = b; t_is = is; t_os = os; t_il = il; t_ol = ol;
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = 2'(m); cfg_esize = 2'(e); cfg_base = b;
        cfg_istride = is; cfg_ostride = os; cfg_ilen = LW'(il); cfg_olen = LW'(ol);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_stream(input bit poke);
        int r = 0, c = 0, p = 0, cyc = 0, lanes, total;
        bit done = 0, stall = 0, bad_rdy = 0;
        logic [VL*AW-1:0] ea, sv_addr;
        logic [VL-1:0] em, sv_mask;
        logic eeor, eeos, sv_eor, sv_eos;
        string req;
        req = (t_mode == 0) ? "R2" : (t_mode == 1) ? "R4" : "R5";
        total = t_il * t_ol;
        start = 1'b1;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            start = 1'b0; cfg_we = 1'b0;
            if (poke && (cyc == 2 || cyc == 4)) begin
                // R8: write and restart attempts while running
                cfg_we = 1'b1; cfg_olen = LW'(t_ol + 3); cfg_ilen = LW'(t_il + 2);
                cfg_base = t_base ^ 32'h5555_0000; cfg_mode = 2'(t_mode ^ 1); start = 1'b1;
            end
            out_ready = ($urandom % 4) != 0;
            if (t_mode == 2 && p < total) begin
                idx_valid = ($urandom % 3) != 0;
                idx_data = idx_of(p);
            end else idx_valid = 1'b0;
            #1;
            if (stall)
                chk(out_valid && out_addr == sv_addr && out_mask == sv_mask &&
                    out_eor == sv_eor && out_eos == sv_eos, "R7", "stall hold",
                    {out_valid, out_eor, out_eos, out_mask, out_addr},
                    {1'b1, sv_eor, sv_eos, sv_mask, sv_addr});
            stall = 0;
            if (t_mode != 2 && idx_ready) bad_rdy = 1;
            if (out_valid) begin
                lanes = row_len(r) - c;
                if (lanes > VL) lanes = VL;
                if (t_mode == 2)
                    chk(p - (r * t_il + c) == lanes, "R5", "indices before valid",
                        (VL*AW+8)'(p - (r * t_il + c)), (VL*AW+8)'(lanes));
                ea = '0; em = '0;
                for (int l = 0; l < VL; l++) begin
                    if (l < lanes) begin
                        em[l] = 1'b1;
                        ea[l*AW +: AW] = lane_addr(r, c + l);
                    end
                end
                eeor = (c + VL >= row_len(r));
                eeos = eeor && (r == t_ol - 1);
                chk(out_addr == ea && out_mask == em && out_eor == eeor && out_eos == eeos,
                    poke ? {req, "/R3/R6/R8"} : {req, "/R3/R6"}, "group",
                    {1'b0, out_eor, out_eos, out_mask, out_addr},
                    {1'b0, eeor, eeos, em, ea});
                if (out_ready) begin
                    if (eeos) done = 1;
                    else if (eeor) begin r++; c = 0; end
                    else c += VL;
                end else begin
                    stall = 1; sv_addr = out_addr; sv_mask = out_mask;
                    sv_eor = out_eor; sv_eos = out_eos;
                end
            end
            if (idx_valid && idx_ready) p++;
            cyc++;
        end
        chk(done, "R6", "stream finished", (VL*AW+8)'(done), (VL*AW+8)'(1));
        if (t_mode != 2) chk(!bad_rdy, "R5", "idx_ready outside indirect",
                             (VL*AW+8)'(bad_rdy), '0);
        @(negedge clk);
        out_ready = 1'b0; idx_valid = 1'b0; start = 1'b0; cfg_we = 1'b0;
        #1;
        chk(!out_valid, "R10", "valid after final group", (VL*AW+8)'(out_valid), '0);
    endtask

    task automatic empty_case(input int m, input int il, input int ol);
        load_desc(m, 0, 32'h100, 32'd1, 32'd4, il, ol);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(out_eos && !out_valid, "R9", "empty eos pulse",
            (VL*AW+8)'({out_eos, out_valid}), (VL*AW+8)'(2'b10));
        @(negedge clk);
        #1;
        chk(!out_eos && !out_valid, "R9", "empty eos single",
            (VL*AW+8)'({out_eos, out_valid}), '0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20211));
        repeat (3) @(negedge clk);
        #1;
        // R1
        chk(!out_valid && !idx_ready && !out_eos, "R1", "reset outputs",
            (VL*AW+8)'({out_valid, idx_ready, out_eos}), '0);
        rst_n = 1'b1;

        load_desc(0, 2, 32'h1000, 32'd1, 32'd16, 8, 3);  run_stream(0); // exact multiple
        load_desc(0, 0, 32'h2000, 32'd3, 32'd7, 5, 2);   run_stream(1); // padded tail, R8
        load_desc(0, 3, 32'hFFFF_FFF0, 32'd2, 32'd9, 1, 4); run_stream(0); // single lane, wrap
        load_desc(1, 1, 32'h3000, 32'd1, 32'd10, 0, 6);  run_stream(0); // triangular
        load_desc(1, 2, 32'h3100, 32'd2, 32'd20, 9, 5);  run_stream(1); // tri ignores ilen
        load_desc(2, 2, 32'h4000, 32'd0, 32'd0, 5, 2);   run_stream(0); // indirect tail
        load_desc(2, 3, 32'h5000, 32'd0, 32'd0, 4, 3);   run_stream(1); // indirect, R8
        empty_case(0, 4, 0);
        empty_case(0, 0, 3);
        empty_case(2, 0, 2);
        empty_case(1, 0, 0);
        load_desc(1, 0, 32'h6000, 32'd1, 32'd8, 0, 2);   run_stream(0); // R10 restart after empty

        for (int i = 0; i < 30; i++) begin
            load_desc(int'($urandom % 3), int'($urandom % 4), $urandom & 32'hFFFF_FF00,
                      AW'($urandom % 5), AW'($urandom % 64),
                      1 + int'($urandom % 10), 1 + int'($urandom % 6));
            run_stream(i % 5 == 0);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule